// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block forms the byte that a host sees when it reads a flash-style memory while an automatic program or erase operation is running. An embedding engine (outside this block) reports whether a program or an erase is busy, whether the window for adding further erase targets is still open, whether its pulse budget has run out, and when it has finished. The engine also supplies the top data bit of the value being programmed. From these inputs the block builds a status byte with four indicators. A polling bit shows the inverse of the target bit during a program, or 0 during an erase. A toggle bit flips on every status read. A timeout bit shows the pulse-limit fault. A timer bit shows whether an erase has begun.

Each read strobe produces one result byte, registered, one cycle later. When no operation is running and no fault is held, the block returns the array data for the addressed location unchanged. A pulse-limit fault freezes the status indicators in their running form, even after the engine goes idle. Only the fault-clear input, which the command decoder raises on a reset command, releases them. The toggle state is cleared at the start of every operation, so the first status read of any operation returns a known value.

Top module: `opstat_reporter`

## Requirements
- R1: After reset, `rd_valid` is 0 and `rd_data` is all zeros until the first read strobe.
- R2: A strobe in cycle N gives `rd_valid` = 1 and `rd_data` in cycle N+1 only. With no operation busy and no fault held, `rd_data` equals the `arr_data` sampled with the strobe.
- R3: During a program (`prog_busy` = 1, `erase_busy` = 0), bit 7 of a status read is the inverse of `prog_bit7`.
- R4: During an erase (`erase_busy` = 1), bit 7 of a status read is 0. Once the erase has ended, reads return array data, so bit 7 is the true bit.
- R5: Bit 6 of the status reads of one operation follows 0, 1, 0, 1, ..., starting at 0 on the first read after busy rises.
- R6: `limit_hit` while busy sets bit 5 to 1 in that same read and holds it. While it is held, bit 7 keeps its running value and bit 6 keeps toggling, even after busy drops.
- R7: Bit 3 is 0 during a program, 0 during an erase while `load_window` = 1, and 1 during an erase once `load_window` = 0.
- R8: Bits 4, 2, 1 and 0 of every status read are 0.
- R9: A read in a cycle where `op_done` = 1, with no fault held, returns array data even though busy is still high.
- R10: After a cycle with `fault_clr` = 1, reads return array data again when the engine is idle.
- R11: Cycles without a strobe do not advance the toggle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_busy | input | 1 | Engine is programming |
| erase_busy | input | 1 | Engine is erasing (sector or chip) |
| load_window | input | 1 | Window for adding erase targets still open |
| limit_hit | input | 1 | Engine pulse limit exceeded |
| op_done | input | 1 | Operation completes this cycle |
| fault_clr | input | 1 | Reset command: release a held timeout |
| prog_bit7 | input | 1 | Bit 7 of the value being programmed |
| rd_stb | input | 1 | Read strobe, one result per strobe |
| arr_data | input | DATA_W | Array data at the read address |
| rd_valid | output | 1 | Result byte valid |
| rd_data | output | DATA_W | Result byte |

## Verification
A wrong toggle register shows on the second status read of an operation, or on the first read after an operation starts, as a bit 6 that repeats instead of flipping. A lost or stuck fault latch shows on the very next read after busy drops, as array data where a status byte with bit 5 set is due, or the reverse after `fault_clr`. A wrong latched operation kind or target bit shows as the wrong bit 7 or bit 3 on a read taken while a fault is held after the engine is idle. Every such error appears at `rd_data` one cycle after the strobe that exposes it.

// File: rtl/opstat_pkg.sv
package opstat_pkg;

    // Bit positions of the status indicators (decoded by host software)
    localparam int POS_POLL  = 7;
    localparam int POS_TOG   = 6;
    localparam int POS_TMO   = 5;
    localparam int POS_TIMER = 3;
    localparam int STAT_W    = 8;

    typedef struct packed {
        logic busy;   // engine busy in previous cycle
        logic tog;    // toggle value for the next status read
        logic pbit;   // latched target bit 7 of the program
        logic erase;  // latched kind: 1 = erase
        logic fault;  // held pulse-limit timeout
    } trk_t;

    typedef struct packed {
        logic valid;
    } oreg_ctl_t;

endpackage

// File: rtl/opstat_track.sv
module opstat_track
    import opstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prog_busy,
    input  logic erase_busy,
    input  logic limit_hit,
    input  logic op_done,
    input  logic fault_clr,
    input  logic prog_bit7,
    input  logic rd_stb,
    output logic stat_o,
    output logic tog_o,
    output logic pbit_o,
    output logic erase_o,
    output logic fault_o
);

    trk_t st_d, st_q;
    logic busy, start, fault_e, stat_e, tog_e, pbit_e, erase_e;

    always_comb begin
        busy    = prog_busy | erase_busy;
        start   = busy & ~st_q.busy;
        fault_e = st_q.fault | (busy & limit_hit);
        stat_e  = fault_e | (busy & ~op_done);
        tog_e   = start ? 1'b0 : st_q.tog;
        pbit_e  = prog_busy ? prog_bit7 : st_q.pbit;
        erase_e = busy ? erase_busy : st_q.erase;

        st_d       = st_q;
        st_d.busy  = busy;
        st_d.tog   = (rd_stb & stat_e) ? ~tog_e : tog_e;
        st_d.pbit  = pbit_e;
        st_d.erase = erase_e;
        st_d.fault = fault_clr ? 1'b0 : fault_e;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o  = stat_e;
    assign tog_o   = tog_e;
    assign pbit_o  = pbit_e;
    assign erase_o = erase_e;
    assign fault_o = fault_e;

endmodule

// File: rtl/opstat_compose.sv
module opstat_compose
    import opstat_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              stat,
    input  logic              tog,
    input  logic              pbit,
    input  logic              erase,
    input  logic              fault,
    input  logic              load_window,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] byte_o
);

    logic [STAT_W-1:0] sbyte;

    always_comb begin
        sbyte            = '0;
        sbyte[POS_POLL]  = erase ? 1'b0 : ~pbit;
        sbyte[POS_TOG]   = tog;
        sbyte[POS_TMO]   = fault;
        sbyte[POS_TIMER] = erase & ~load_window;
    end

    generate
        if (DATA_W > STAT_W) begin : g_wide
            assign byte_o = stat ? {{(DATA_W-STAT_W){1'b0}}, sbyte} : arr_data;
        end else begin : g_narrow
            assign byte_o = stat ? sbyte[DATA_W-1:0] : arr_data;
        end
    endgenerate

endmodule

// File: rtl/opstat_outreg.sv
module opstat_outreg
    import opstat_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] byte_i,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    oreg_ctl_t         ctl_d, ctl_q;
    logic [DATA_W-1:0] dat_d, dat_q;

    always_comb begin
        ctl_d.valid = rd_stb;
        dat_d       = rd_stb ? byte_i : dat_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            dat_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            dat_q <= dat_d;
        end
    end

    assign rd_valid = ctl_q.valid;
    assign rd_data  = dat_q;

endmodule

// File: rtl/opstat_reporter.sv
module opstat_reporter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_busy,
    input  logic              erase_busy,
    input  logic              load_window,
    input  logic              limit_hit,
    input  logic              op_done,
    input  logic              fault_clr,
    input  logic              prog_bit7,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] arr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic stat, tog, pbit, erase, fault;
    logic [DATA_W-1:0] byte_w;

    opstat_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_busy  (prog_busy),
        .erase_busy (erase_busy),
        .limit_hit  (limit_hit),
        .op_done    (op_done),
        .fault_clr  (fault_clr),
        .prog_bit7  (prog_bit7),
        .rd_stb     (rd_stb),
        .stat_o     (stat),
        .tog_o      (tog),
        .pbit_o     (pbit),
        .erase_o    (erase),
        .fault_o    (fault)
    );

    opstat_compose #(.DATA_W(DATA_W)) u_compose (
        .stat        (stat),
        .tog         (tog),
        .pbit        (pbit),
        .erase       (erase),
        .fault       (fault),
        .load_window (load_window),
        .arr_data    (arr_data),
        .byte_o      (byte_w)
    );

    opstat_outreg #(.DATA_W(DATA_W)) u_outreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .byte_i   (byte_w),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/opstat_sva.sv
module opstat_sva #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_busy,
    input logic              erase_busy,
    input logic              limit_hit,
    input logic              op_done,
    input logic              fault_clr,
    input logic              prog_bit7,
    input logic              rd_stb,
    input logic [DATA_W-1:0] arr_data,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data
);

    // Independent shadow of the held timeout
    logic ck_fault;
    always_ff @(posedge clk) begin
        if (!rst_n)         ck_fault <= 1'b0;
        else if (fault_clr) ck_fault <= 1'b0;
        else if ((prog_busy | erase_busy) & limit_hit) ck_fault <= 1'b1;
    end

    logic run;
    assign run = (prog_busy | erase_busy) & ~op_done;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);

    a_r2_valid_only_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_valid);

    a_r2_idle_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !prog_busy && !erase_busy && !ck_fault)
        |=> rd_data == $past(arr_data));

    a_r3_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && prog_busy && !erase_busy && !op_done)
        |=> rd_data[7] == !$past(prog_bit7));

    a_r4_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && erase_busy && !op_done) |=> rd_data[7] == 1'b0);

    a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && run && $past(rd_stb && run))
        |=> rd_data[6] != $past(rd_data[6]));

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && run)
        |=> (rd_data[4] == 1'b0 && rd_data[2:0] == 3'b000));

    a_r6_timeout_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (ck_fault || ((prog_busy | erase_busy) && limit_hit)))
        |=> rd_data[5] == 1'b1);

endmodule

bind opstat_reporter opstat_sva #(.DATA_W(DATA_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_busy  (prog_busy),
    .erase_busy (erase_busy),
    .limit_hit  (limit_hit),
    .op_done    (op_done),
    .fault_clr  (fault_clr),
    .prog_bit7  (prog_bit7),
    .rd_stb     (rd_stb),
    .arr_data   (arr_data),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
);

// File: tb/opstat_reporter_tb_top.sv
module opstat_reporter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_busy = 1'b0, erase_busy = 1'b0, load_window = 1'b0;
    logic       limit_hit = 1'b0, op_done = 1'b0, fault_clr = 1'b0;
    logic       prog_bit7 = 1'b0, rd_stb = 1'b0;
    logic [7:0] arr_data = 8'h00;
    logic       rd_valid;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    opstat_reporter #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .erase_busy(erase_busy),
        .load_window(load_window), .limit_hit(limit_hit), .op_done(op_done),
        .fault_clr(fault_clr), .prog_bit7(prog_bit7), .rd_stb(rd_stb),
        .arr_data(arr_data), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Status byte built from the requirement bit positions
    function automatic logic [7:0] sbyte(logic b7, logic b6, logic b5, logic b3);
        return {b7, b6, b5, 1'b0, b3, 3'b000};
    endfunction

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // Called at a negedge; strobes one read and checks the result after the edge
    task automatic do_read(input logic [7:0] exp, input string tag);
        rd_stb = 1'b1;
        @(posedge clk); #1;
        check({7'd0, rd_valid}, 8'h01, {tag, " valid"});
        check(rd_data, exp, tag);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic t_reset();
        check({7'd0, rd_valid}, 8'h00, "R1 valid after reset");
        check(rd_data, 8'h00, "R1 data after reset");
    endtask

    task automatic t_idle();
        arr_data = 8'hA5;
        do_read(8'hA5, "R2 idle passthrough");
        @(posedge clk); #1;
        check({7'd0, rd_valid}, 8'h00, "R2 valid drops");
        @(negedge clk);
        arr_data = 8'h3C;
        do_read(8'h3C, "R2 idle second pattern");
    endtask

    task automatic t_program();
        arr_data = 8'hFF; prog_bit7 = 1'b1; prog_busy = 1'b1;
        do_read(sbyte(1'b0, 1'b0, 1'b0, 1'b0), "R3 R5 R7 R8 prog read 1");
        do_read(sbyte(1'b0, 1'b1, 1'b0, 1'b0), "R5 prog read 2");
        repeat (3) @(negedge clk);
        do_read(sbyte(1'b0, 1'b0, 1'b0, 1'b0), "R11 no advance without strobe");
        op_done = 1'b1;
        do_read(8'hFF, "R9 done cycle returns data");
        op_done = 1'b0; prog_busy = 1'b0;
        arr_data = 8'h80;
        do_read(8'h80, "R3 true data after program");
    endtask

    task automatic t_erase();
        arr_data = 8'h12; erase_busy = 1'b1; load_window = 1'b1;
        do_read(sbyte(1'b0, 1'b0, 1'b0, 1'b0), "R4 R5 R7 erase in window");
        load_window = 1'b0;
        do_read(sbyte(1'b0, 1'b1, 1'b0, 1'b1), "R7 erase window closed");
        do_read(sbyte(1'b0, 1'b0, 1'b0, 1'b1), "R5 erase read 3");
        erase_busy = 1'b0; arr_data = 8'hFF;
        do_read(8'hFF, "R4 erase complete reads ones");
    endtask

    task automatic t_fault();
        arr_data = 8'h00; prog_bit7 = 1'b0; prog_busy = 1'b1;
        do_read(sbyte(1'b1, 1'b0, 1'b0, 1'b0), "R3 prog bit7 zero target");
        limit_hit = 1'b1;
        do_read(sbyte(1'b1, 1'b1, 1'b1, 1'b0), "R6 timeout set");
        limit_hit = 1'b0; prog_busy = 1'b0;
        do_read(sbyte(1'b1, 1'b0, 1'b1, 1'b0), "R6 held after idle");
        do_read(sbyte(1'b1, 1'b1, 1'b1, 1'b0), "R6 toggle continues");
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        do_read(8'h00, "R10 cleared passthrough");
        erase_busy = 1'b1; load_window = 1'b0;
        limit_hit = 1'b1;
        do_read(sbyte(1'b0, 1'b0, 1'b1, 1'b1), "R5 R6 new erase toggle cleared");
        limit_hit = 1'b0; erase_busy = 1'b0;
        do_read(sbyte(1'b0, 1'b1, 1'b1, 1'b1), "R6 erase fault held");
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0; arr_data = 8'h5A;
        do_read(8'h5A, "R10 erase fault cleared");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_program();
        t_erase();
        t_fault();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule